// File: doc/BRIEF.md
# NCO Phase and Frequency Control

This block computes the instantaneous phase word of a numerically controlled oscillator. A 32-bit phase accumulator moves forward once per enabled clock. Each step is the sum of two programmable frequency terms: a center term and an offset term. A programmable phase offset is added to the accumulated phase. A 3-bit discrete PSK code then turns the result further in steps of one eighth of a cycle. The registered sum is the phase word handed to a sine/cosine stage. A full 32-bit range corresponds to one counterclockwise turn starting at 0°.

Control values arrive over a simple write bus and land in shadow registers. Two discrete strobes copy the shadows into the active set. One strobe updates both frequency terms on the same clock. The other updates the phase offset. This lets FM, FSK, PSK and MSK waveforms be produced in real time. A continuous tone results when the controls are left alone. A clock enable pauses the accumulator, and a synchronous clear returns it to zero.

Top module: `nco_phase_ctrl`

## Requirements
- R1: While `rst` is high, and on the first edge after it, all shadow and active control registers, the accumulator and `phase_o` are zero.
- R2: On every rising edge with `ce` high and `clear` low, the accumulator increases by the active center term plus the active offset term. The sum wraps modulo 2^32.
- R3: On a rising edge with `ce` low and `clear` low, the accumulator keeps its value.
- R4: On a rising edge with `clear` high, the accumulator becomes zero, whatever `ce` is.
- R5: With `wr_en` high, `wr_data` is written to a shadow register chosen by `wr_addr`: 0 selects center, 1 selects offset and 2 selects phase offset. Address 3 is ignored. A write alone never changes the accumulator or `phase_o`.
- R6: On a rising edge with `freq_load` high, both active frequency terms take their shadow values as they were before that edge, on the same cycle.
- R7: On a rising edge with `phase_load` high, the active phase offset takes its shadow value as it was before that edge.
- R8: At each rising edge, `phase_o` becomes (accumulator + active phase offset + `psk_sel`·2^29) mod 2^32, using the values held before that edge. The output therefore trails the accumulator by one cycle.
- R9: PSK code k in 0..7 on `psk_sel` rotates `phase_o` by k·45°, that is k·2^29. The change appears on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Accumulator advance enable |
| clear | input | 1 | Synchronous accumulator clear |
| wr_en | input | 1 | Shadow register write strobe |
| wr_addr | input | 2 | Shadow register select (0 center, 1 offset, 2 phase offset) |
| wr_data | input | 32 | Write data |
| freq_load | input | 1 | Copy both frequency shadows to active |
| phase_load | input | 1 | Copy phase offset shadow to active |
| psk_sel | input | 3 | PSK rotation code, k·45° |
| phase_o | output | 32 | Registered instantaneous phase word |

## Verification
A wrong accumulator value shows up at `phase_o` one edge later. Because the error is never corrected, every later sample carries the same constant phase error. A wrong active frequency term shows up differently: the difference between successive outputs drifts away from the programmed step. It becomes visible two edges after the load. A wrong shadow or active phase offset appears as a constant bias on `phase_o`, one edge after `phase_load`. An error in the PSK path appears as an output that is off by a multiple of 2^29 on the edge after the code changes.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int PHASE_W   = 32;
    localparam int PSK_W     = 3;
    localparam int ADDR_W    = 2;
    localparam int PSK_SHIFT = PHASE_W - PSK_W;

    typedef logic [PHASE_W-1:0] phase_t;
    typedef logic [PSK_W-1:0]   psk_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CENTER = 2'd0,
        SEL_OFFSET = 2'd1,
        SEL_PHASE  = 2'd2,
        SEL_NONE   = 2'd3
    } nco_sel_e;

    typedef struct packed {
        phase_t center;
        phase_t offset;
        phase_t poff;
    } nco_ctl_t;

    // k eighths of a turn expressed as a phase word
    function automatic phase_t psk_rot(input psk_t k);
        return phase_t'(k) << PSK_SHIFT;
    endfunction

    // per-clock increment from the two frequency terms, wraps
    function automatic phase_t freq_step(input nco_ctl_t c);
        return c.center + c.offset;
    endfunction

endpackage

// File: rtl/nco_ctl_regs.sv
module nco_ctl_regs
    import nco_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  nco_sel_e wr_sel,
    input  phase_t   wr_data,
    input  logic     freq_load,
    input  logic     phase_load,
    output nco_ctl_t shd,
    output nco_ctl_t act
);

    nco_ctl_t shd_q, act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_CENTER: shd_q.center <= wr_data;
                SEL_OFFSET: shd_q.offset <= wr_data;
                SEL_PHASE:  shd_q.poff   <= wr_data;
                default:    shd_q        <= shd_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else begin
            if (freq_load) begin
                act_q.center <= shd_q.center;
                act_q.offset <= shd_q.offset;
            end
            if (phase_load) begin
                act_q.poff <= shd_q.poff;
            end
        end
    end

    assign shd = shd_q;
    assign act = act_q;

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
    import nco_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ce,
    input  logic   clear,
    input  phase_t step,
    output phase_t acc
);

    phase_t acc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
        end else if (ce) begin
            acc_q <= acc_q + step;
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/nco_phase_out.sv
module nco_phase_out
    import nco_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t acc,
    input  phase_t poff,
    input  psk_t   psk,
    output phase_t phase
);

    phase_t shift_total;
    phase_t phase_q;

    always_comb begin
        shift_total = poff + psk_rot(psk);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= acc + shift_total;
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/nco_phase_ctrl.sv
module nco_phase_ctrl
    import nco_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ce,
    input  logic               clear,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [PHASE_W-1:0] wr_data,
    input  logic               freq_load,
    input  logic               phase_load,
    input  logic [PSK_W-1:0]   psk_sel,
    output logic [PHASE_W-1:0] phase_o
);

    nco_ctl_t shd, act;
    phase_t   step;
    phase_t   acc_q;
    phase_t   phase_w;

    nco_ctl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (nco_sel_e'(wr_addr)),
        .wr_data    (wr_data),
        .freq_load  (freq_load),
        .phase_load (phase_load),
        .shd        (shd),
        .act        (act)
    );

    assign step = freq_step(act);

    nco_phase_acc u_acc (
        .clk   (clk),
        .rst   (rst),
        .ce    (ce),
        .clear (clear),
        .step  (step),
        .acc   (acc_q)
    );

    nco_phase_out u_out (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc_q),
        .poff  (act.poff),
        .psk   (psk_sel),
        .phase (phase_w)
    );

    assign phase_o = phase_w;

endmodule

// File: rtl/nco_phase_ctrl_chk.sv
module nco_phase_ctrl_chk
    import nco_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     ce,
    input logic     clear,
    input logic     freq_load,
    input logic     phase_load,
    input psk_t     psk_sel,
    input phase_t   phase_o,
    input phase_t   acc_q,
    input nco_ctl_t shd,
    input nco_ctl_t act
);

    // R2
    advance_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && !clear) |=> acc_q == $past(acc_q) + $past(act.center) + $past(act.offset));

    // R3
    hold_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce && !clear) |=> $stable(acc_q));

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> acc_q == '0);

    // R6
    freq_pair_chk: assert property (@(posedge clk) disable iff (rst)
        freq_load |=> (act.center == $past(shd.center)) && (act.offset == $past(shd.offset)));

    // R5
    freq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !freq_load |=> $stable(act.center) && $stable(act.offset));

    // R7
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !phase_load |=> $stable(act.poff));

    // R8
    out_latency_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> phase_o == $past(acc_q) + $past(act.poff) + ($past(phase_t'(psk_sel)) << PSK_SHIFT));

endmodule

bind nco_phase_ctrl nco_phase_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ce         (ce),
    .clear      (clear),
    .freq_load  (freq_load),
    .phase_load (phase_load),
    .psk_sel    (psk_sel),
    .phase_o    (phase_o),
    .acc_q      (acc_q),
    .shd        (shd),
    .act        (act)
);

// File: tb/tb_nco_phase_ctrl.sv
`timescale 1ns/1ps
module tb_nco_phase_ctrl;

    logic        clk = 1'b0;
    logic        rst, ce, clear, wr_en, freq_load, phase_load;
    logic [1:0]  wr_addr;
    logic [31:0] wr_data;
    logic [2:0]  psk_sel;
    logic [31:0] phase_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model state
    logic [31:0] m_cs, m_os, m_ps, m_ca, m_oa, m_pa, m_acc, m_out;

    always #2.5 clk = ~clk;

    nco_phase_ctrl dut (
        .clk(clk), .rst(rst), .ce(ce), .clear(clear), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .freq_load(freq_load),
        .phase_load(phase_load), .psk_sel(psk_sel), .phase_o(phase_o)
    );

    function automatic logic [31:0] rot8(input logic [2:0] k);
        return {k, 29'd0};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: phase_o=%h expected %h", tag, got, exp);
        end
    endtask

    // model update with pre-edge values, called right after the edge
    task automatic model_edge();
        logic [31:0] n_acc, n_out;
        if (rst) begin
            m_cs = 0; m_os = 0; m_ps = 0; m_ca = 0; m_oa = 0; m_pa = 0;
            m_acc = 0; m_out = 0;
        end else begin
            n_out = m_acc + m_pa + rot8(psk_sel);
            n_acc = clear ? 32'd0 : (ce ? m_acc + m_ca + m_oa : m_acc);
            if (freq_load) begin m_ca = m_cs; m_oa = m_os; end
            if (phase_load) m_pa = m_ps;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_cs = wr_data;
                    2'd1: m_os = wr_data;
                    2'd2: m_ps = wr_data;
                    default: ;
                endcase
            end
            m_acc = n_acc;
            m_out = n_out;
        end
    endtask

    task automatic step(input logic i_ce, input logic i_clr, input logic i_we,
                        input logic [1:0] i_a, input logic [31:0] i_d,
                        input logic i_fl, input logic i_pl, input logic [2:0] i_k,
                        input string tag);
        @(negedge clk);
        ce = i_ce; clear = i_clr; wr_en = i_we; wr_addr = i_a; wr_data = i_d;
        freq_load = i_fl; phase_load = i_pl; psk_sel = i_k;
        @(posedge clk);
        model_edge();
        #1;
        check(tag, phase_o, m_out);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: phase_o=%h expected completion", phase_o);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        rst = 1'b1; ce = 0; clear = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
        freq_load = 0; phase_load = 0; psk_sel = 0;
        repeat (3) begin
            @(posedge clk); model_edge();
        end
        #1 check("R1 reset", phase_o, 32'd0);
        @(negedge clk); rst = 1'b0;
        step(1, 0, 0, 0, 0, 0, 0, 0, "R1 first edge");
        if (phase_o !== 32'd0) check("R1 zero after reset", phase_o, 32'd0);

        // writes without load must not move anything (R5)
        step(1, 0, 1, 2'd0, 32'h1000_0000, 0, 0, 0, "R5 write center");
        step(1, 0, 1, 2'd1, 32'h0000_0100, 0, 0, 0, "R5 write offset");
        step(1, 0, 1, 2'd2, 32'h0000_0040, 0, 0, 0, "R5 write phase");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R5 no load");
        check("R5 output still zero", phase_o, 32'd0);

        // load both frequency halves together (R6, R2)
        step(1, 0, 0, 0, 0, 1, 0, 0, "R6 freq load");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R2 advance");
        check("R2 step count", phase_o, 32'h3000_0300);

        // hold (R3)
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R3 hold");

        // clear with ce high (R4)
        step(1, 1, 0, 0, 0, 0, 0, 0, "R4 clear");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R4 after clear");
        check("R4 output zero", phase_o, 32'd0);

        // address 3 ignored (R5)
        step(0, 0, 1, 2'd3, 32'hDEAD_BEEF, 0, 0, 0, "R5 addr3");
        step(0, 0, 0, 0, 0, 1, 1, 0, "R5 addr3 load");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R5 addr3 result");

        // phase offset load (R7)
        step(0, 0, 1, 2'd2, 32'h0123_4567, 0, 0, 0, "R7 write");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R7 load");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R7 applied");

        // PSK sweep with accumulator frozen (R9)
        for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 0, 0, 0, 3'(k), "R9 psk");

        // wrap (R2): step = 0xFFFFFFFF + 2 = 1
        step(0, 1, 1, 2'd0, 32'hFFFF_FFFF, 0, 0, 0, "R2 wrap setup");
        step(0, 0, 1, 2'd1, 32'd2, 0, 0, 0, "R2 wrap setup");
        step(0, 0, 1, 2'd2, 32'hFFFF_FFFF, 1, 1, 3'd7, "R2 wrap load");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0, 3'd7, "R2 wrap");

        // random mix (R8)
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], (r[7:2] == 0), r[8], r[10:9], $urandom,
                 (r[13:11] == 0), (r[16:14] == 0), r[19:17], "R8 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule